// File: doc/BRIEF.md
# Block Memory Transfer Engine

This block moves a run of bytes from one place in a 16-bit address space to another. It has four internal 16-bit pointer registers and one 16-bit byte-count register. A transfer names one pointer as the source, names one as the destination, and uses one of four stepping styles. Each byte takes one read and one write on a single synchronous memory port. The engine steps the chosen pointers and decrements the count in place as it goes, so at the end the registers show where the transfer stopped.

The two styles with one fixed pointer let a single engine fill an I/O location from a buffer, or drain an I/O location into a buffer. The engine needs no extra address logic for this. A pause input stops the engine at a byte boundary without losing any state, so an interrupt can be serviced mid-transfer and the transfer then resumes.

Each transfer costs a fixed overhead of six cycles plus three cycles per byte, not counting paused cycles. Pointers and the count are loaded through a small register write port while the engine is idle. Their contents can be read on dedicated outputs.

Top module: `bmove_engine`

## Requirements
- R1: After reset, `busy`, `memRe` and `memWe` are low, and all four pointers and the count read zero.
- R2: While idle, a write on the register port loads the register named by its code. The codes are 0001 for pointer X, 0010 for Y, 0011 for U, 0100 for S and 0110 for the count. A write with any other code changes nothing. A write made while `busy` is high changes nothing.
- R3: Mode 0 reads at the source pointer and writes to the destination pointer, and both pointers advance by one per byte. At completion each pointer sits one past the last byte in the direction of travel.
- R4: Mode 1 works like mode 0, except that both pointers decrease by one per byte.
- R5: Mode 2 advances the source pointer by one per byte and writes every byte to the same destination address. The destination pointer keeps its value.
- R6: Mode 3 reads every byte from the same source address and advances the destination pointer by one per byte. The source pointer keeps its value.
- R7: When nothing is paused, `busy` stays high for exactly 6 + 3n cycles after `start` is accepted, where n is the starting count. Each byte's write comes exactly two cycles after its read, and the port never reads and writes in the same cycle.
- R8: The count decreases by one with each byte written and reads zero when the transfer ends.
- R9: A transfer that starts with a count of zero makes no memory access and keeps `busy` high for 6 cycles.
- R10: When the source and destination name the same pointer, the pointer takes its source step right after the read. It takes its destination step right after the write, so the write uses the value already stepped once.
- R11: While `pause` is high, the engine holds at the next byte boundary. It makes no access and leaves the pointers and count unchanged. When `pause` is released, the transfer continues from the held state.
- R12: `start` is ignored while `busy` is high, and also when either pointer code is outside 0001 to 0100.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer (sampled while idle) |
| mode | input | 2 | Stepping style 0..3 |
| srcCode | input | 4 | Source pointer code |
| dstCode | input | 4 | Destination pointer code |
| pause | input | 1 | Hold at the next byte boundary |
| regWrEn | input | 1 | Register write strobe |
| regWrCode | input | 4 | Register code for the write |
| regWrData | input | 16 | Register write value |
| memAddr | output | 16 | Memory address |
| memRe | output | 1 | Memory read strobe; data returns the next cycle |
| memWe | output | 1 | Memory write strobe |
| memWData | output | 8 | Memory write data |
| memRData | input | 8 | Memory read data |
| busy | output | 1 | Transfer in progress |
| ptrX | output | 16 | Pointer X contents |
| ptrY | output | 16 | Pointer Y contents |
| ptrU | output | 16 | Pointer U contents |
| ptrS | output | 16 | Pointer S contents |
| countW | output | 16 | Byte count contents |

## Verification
A wrong step delta or a wrong register select shows up within one byte. It appears as a wrong `memAddr` on the following access, and as a wrong final pointer value right after `busy` falls. A count that mis-decrements shows up as a `busy` length that is off by a multiple of three cycles, or as a nonzero count at completion. A pause that leaks appears as a read or a count change while `pause` is high, and this is visible in the same cycle on the port or the count output.

// File: rtl/bmove_pkg.sv
package bmove_pkg;
  localparam int NUM_PTR = 4;
  localparam int CODE_W  = 4;
  localparam logic [CODE_W-1:0] CODE_COUNT = 4'b0110;

  typedef enum logic [1:0] {
    MODE_BOTH_UP   = 2'd0,
    MODE_BOTH_DOWN = 2'd1,
    MODE_TO_FIXED  = 2'd2,
    MODE_FROM_FIXED = 2'd3
  } xferMode_t;

  typedef struct packed {
    logic load;
    logic readByte;
    logic captureByte;
    logic writeByte;
  } ctrlStrobe_t;

  function automatic logic ptrCodeOk(input logic [CODE_W-1:0] code);
    return (code >= 4'd1) && (code <= 4'(NUM_PTR));
  endfunction

  function automatic logic [1:0] ptrIdx(input logic [CODE_W-1:0] code);
    logic [CODE_W-1:0] t;
    t = code - 4'd1;
    return t[1:0];
  endfunction
endpackage

// File: rtl/bmove_ctrl.sv
module bmove_ctrl
  import bmove_pkg::*;
#(
  parameter int HEAD_CYC = 3,
  parameter int TAIL_CYC = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              pause,
  input  logic [CODE_W-1:0] srcCode,
  input  logic [CODE_W-1:0] dstCode,
  input  logic              countIsZero,
  input  logic              countIsOne,
  output ctrlStrobe_t       strobes,
  output logic              busy
);
  localparam int MAX_CYC = (HEAD_CYC > TAIL_CYC) ? HEAD_CYC : TAIL_CYC;
  localparam int PH_W = $clog2(MAX_CYC + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_HEAD, ST_READ, ST_WAIT, ST_WRITE, ST_TAIL
  } state_t;

  state_t state, stateNext;
  logic [PH_W-1:0] phase, phaseNext;
  logic codesOk;

  assign codesOk = ptrCodeOk(srcCode) && ptrCodeOk(dstCode);
  assign busy = (state != ST_IDLE);

  always_comb begin
    stateNext = state;
    phaseNext = phase;
    strobes = '0;
    unique case (state)
      ST_IDLE: if (start && codesOk) begin
        strobes.load = 1'b1;
        stateNext = ST_HEAD;
        phaseNext = '0;
      end
      ST_HEAD: begin
        if (phase == PH_W'(HEAD_CYC - 1)) begin
          phaseNext = '0;
          stateNext = countIsZero ? ST_TAIL : ST_READ;
        end else begin
          phaseNext = phase + 1'b1;
        end
      end
      ST_READ: if (!pause) begin
        strobes.readByte = 1'b1;
        stateNext = ST_WAIT;
      end
      ST_WAIT: begin
        strobes.captureByte = 1'b1;
        stateNext = ST_WRITE;
      end
      ST_WRITE: begin
        strobes.writeByte = 1'b1;
        phaseNext = '0;
        stateNext = countIsOne ? ST_TAIL : ST_READ;
      end
      ST_TAIL: begin
        if (phase == PH_W'(TAIL_CYC - 1)) begin
          phaseNext = '0;
          stateNext = ST_IDLE;
        end else begin
          phaseNext = phase + 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      phase <= '0;
    end else begin
      state <= stateNext;
      phase <= phaseNext;
    end
  end

  // R7: every write is the second cycle after its read
  a_r7_write_after_read: assert property (@(posedge clk) disable iff (!rstN)
    strobes.writeByte |-> $past(strobes.readByte, 2));

  // R9: no access strobes while idle
  a_r9_quiet_when_idle: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !(strobes.readByte || strobes.writeByte));

  // R12: a bad pointer code leaves the engine idle
  a_r12_reject_bad_code: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start && !codesOk) |=> !busy);

  // R11: while paused the engine never issues a read
  a_r11_pause_no_read: assert property (@(posedge clk) disable iff (!rstN)
    (pause && $past(strobes.writeByte)) |-> !strobes.readByte);
endmodule

// File: rtl/bmove_datapath.sv
module bmove_datapath
  import bmove_pkg::*;
#(
  parameter int REG_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobes,
  input  logic              busy,
  input  logic [1:0]        modeIn,
  input  logic [CODE_W-1:0] srcCode,
  input  logic [CODE_W-1:0] dstCode,
  input  logic              regWrEn,
  input  logic [CODE_W-1:0] regWrCode,
  input  logic [REG_W-1:0]  regWrData,
  input  logic [DATA_W-1:0] memRData,
  output logic [REG_W-1:0]  memAddr,
  output logic              memRe,
  output logic              memWe,
  output logic [DATA_W-1:0] memWData,
  output logic              countIsZero,
  output logic              countIsOne,
  output logic [REG_W-1:0]  ptrOut [NUM_PTR],
  output logic [REG_W-1:0]  countW
);
  xferMode_t   modeQ;
  logic [1:0]  srcIdx, dstIdx;
  logic [DATA_W-1:0] byteQ;
  logic [REG_W-1:0] srcDelta, dstDelta;
  logic regWrite;

  assign regWrite = regWrEn && !busy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ  <= MODE_BOTH_UP;
      srcIdx <= '0;
      dstIdx <= '0;
    end else if (strobes.load) begin
      modeQ  <= xferMode_t'(modeIn);
      srcIdx <= ptrIdx(srcCode);
      dstIdx <= ptrIdx(dstCode);
    end
  end

  always_comb begin
    unique case (modeQ)
      MODE_BOTH_UP:    begin srcDelta = REG_W'(1); dstDelta = REG_W'(1); end
      MODE_BOTH_DOWN:  begin srcDelta = '1;        dstDelta = '1;        end
      MODE_TO_FIXED:   begin srcDelta = REG_W'(1); dstDelta = '0;        end
      default:         begin srcDelta = '0;        dstDelta = REG_W'(1); end
    endcase
  end

  for (genvar i = 0; i < NUM_PTR; i++) begin : g_ptr
    logic [REG_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        q <= '0;
      end else if (regWrite && ptrCodeOk(regWrCode) && ptrIdx(regWrCode) == 2'(i)) begin
        q <= regWrData;
      end else if (strobes.readByte && srcIdx == 2'(i)) begin
        q <= q + srcDelta;
      end else if (strobes.writeByte && dstIdx == 2'(i)) begin
        q <= q + dstDelta;
      end
    end
    assign ptrOut[i] = q;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countW <= '0;
    end else if (regWrite && regWrCode == CODE_COUNT) begin
      countW <= regWrData;
    end else if (strobes.writeByte) begin
      countW <= countW - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) byteQ <= '0;
    else if (strobes.captureByte) byteQ <= memRData;
  end

  assign countIsZero = (countW == '0);
  assign countIsOne  = (countW == REG_W'(1));
  assign memRe    = strobes.readByte;
  assign memWe    = strobes.writeByte;
  assign memAddr  = strobes.writeByte ? ptrOut[dstIdx] : ptrOut[srcIdx];
  assign memWData = byteQ;

  // R7: the port carries at most one access per cycle
  a_r7_single_access: assert property (@(posedge clk) disable iff (!rstN)
    !(memRe && memWe));

  // R8: each written byte takes exactly one off the count
  a_r8_count_step: assert property (@(posedge clk) disable iff (!rstN)
    memWe |=> countW == REG_W'($past(countW) - 1'b1));

  // R2: a register write during a transfer leaves the count alone
  a_r2_busy_write_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (busy && regWrEn && !memWe) |=> $stable(countW));
endmodule

// File: rtl/bmove_engine.sv
module bmove_engine
  import bmove_pkg::*;
#(
  parameter int REG_W    = 16,
  parameter int DATA_W   = 8,
  parameter int HEAD_CYC = 3,
  parameter int TAIL_CYC = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [1:0]        mode,
  input  logic [3:0]        srcCode,
  input  logic [3:0]        dstCode,
  input  logic              pause,
  input  logic              regWrEn,
  input  logic [3:0]        regWrCode,
  input  logic [REG_W-1:0]  regWrData,
  output logic [REG_W-1:0]  memAddr,
  output logic              memRe,
  output logic              memWe,
  output logic [DATA_W-1:0] memWData,
  input  logic [DATA_W-1:0] memRData,
  output logic              busy,
  output logic [REG_W-1:0]  ptrX,
  output logic [REG_W-1:0]  ptrY,
  output logic [REG_W-1:0]  ptrU,
  output logic [REG_W-1:0]  ptrS,
  output logic [REG_W-1:0]  countW
);
  ctrlStrobe_t strobes;
  logic countIsZero, countIsOne;
  logic [REG_W-1:0] ptrOut [NUM_PTR];

  bmove_ctrl #(.HEAD_CYC(HEAD_CYC), .TAIL_CYC(TAIL_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .pause(pause),
    .srcCode(srcCode), .dstCode(dstCode),
    .countIsZero(countIsZero), .countIsOne(countIsOne),
    .strobes(strobes), .busy(busy)
  );

  bmove_datapath #(.REG_W(REG_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .busy(busy),
    .modeIn(mode), .srcCode(srcCode), .dstCode(dstCode),
    .regWrEn(regWrEn), .regWrCode(regWrCode), .regWrData(regWrData),
    .memRData(memRData), .memAddr(memAddr), .memRe(memRe), .memWe(memWe),
    .memWData(memWData), .countIsZero(countIsZero), .countIsOne(countIsOne),
    .ptrOut(ptrOut), .countW(countW)
  );

  assign ptrX = ptrOut[0];
  assign ptrY = ptrOut[1];
  assign ptrU = ptrOut[2];
  assign ptrS = ptrOut[3];
endmodule

// File: tb/bmove_engine_bench.sv
module bmove_engine_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] CX = 4'd1, CY = 4'd2, CU = 4'd3, CS = 4'd4, CW = 4'd6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0, pause = 1'b0, regWrEn = 1'b0;
  logic [1:0] mode = '0;
  logic [3:0] srcCode = '0, dstCode = '0, regWrCode = '0;
  logic [15:0] regWrData = '0;
  logic [15:0] memAddr, ptrX, ptrY, ptrU, ptrS, countW;
  logic memRe, memWe, busy;
  logic [7:0] memWData;
  logic [7:0] memRData = '0;

  logic [7:0] mem [4096];
  int rdCnt = 0, wrCnt = 0;
  int checks = 0, errors = 0;
  int lastCycles, midReads, midCount, midX;

  always #(CLK_PERIOD/2) clk = ~clk;

  bmove_engine u_bmove_engine (
    .clk(clk), .rstN(rstN), .start(start), .mode(mode),
    .srcCode(srcCode), .dstCode(dstCode), .pause(pause),
    .regWrEn(regWrEn), .regWrCode(regWrCode), .regWrData(regWrData),
    .memAddr(memAddr), .memRe(memRe), .memWe(memWe), .memWData(memWData),
    .memRData(memRData), .busy(busy), .ptrX(ptrX), .ptrY(ptrY),
    .ptrU(ptrU), .ptrS(ptrS), .countW(countW)
  );

  always @(posedge clk) begin
    if (memRe) begin memRData <= mem[memAddr[11:0]]; rdCnt <= rdCnt + 1; end
    if (memWe) begin mem[memAddr[11:0]] <= memWData; wrCnt <= wrCnt + 1; end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic setReg(input logic [3:0] code, input logic [15:0] val);
    @(negedge clk);
    regWrEn = 1'b1; regWrCode = code; regWrData = val;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic runXfer(input logic [1:0] m, input logic [3:0] s, input logic [3:0] d,
                         input int pauseUntil, input bit poke);
    @(negedge clk);
    start = 1'b1; mode = m; srcCode = s; dstCode = d; pause = (pauseUntil > 0);
    @(negedge clk);
    start = 1'b0;
    lastCycles = 0;
    while (busy && lastCycles < 1000) begin
      lastCycles++;
      if (poke && lastCycles == 2) begin
        regWrEn = 1'b1; regWrCode = CW; regWrData = 16'h0055; start = 1'b1;
      end else begin
        regWrEn = 1'b0; start = 1'b0;
      end
      if (lastCycles == pauseUntil) begin
        midReads = rdCnt; midCount = countW; midX = ptrX; pause = 1'b0;
      end
      @(negedge clk);
    end
    regWrEn = 1'b0; start = 1'b0; pause = 1'b0;
  endtask

  task automatic testReset();
    check(!busy && !memRe && !memWe, "R1 idle strobes", {busy, memRe, memWe}, 0);
    check(ptrX == 0 && ptrY == 0 && ptrU == 0 && ptrS == 0, "R1 pointers", ptrX | ptrY | ptrU | ptrS, 0);
    check(countW == 0, "R1 count", countW, 0);
  endtask

  task automatic testRegPort();
    setReg(CX, 16'h1111); setReg(CY, 16'h2222); setReg(CU, 16'h3333);
    setReg(CS, 16'h4444); setReg(CW, 16'h0007);
    check(ptrX == 16'h1111 && ptrY == 16'h2222, "R2 load X Y", {ptrX, ptrY}, 32'h11112222);
    check(ptrU == 16'h3333 && ptrS == 16'h4444, "R2 load U S", {ptrU, ptrS}, 32'h33334444);
    check(countW == 16'h0007, "R2 load count", countW, 7);
    setReg(4'd5, 16'hDEAD); setReg(4'd0, 16'hBEEF); setReg(4'd15, 16'hCAFE);
    check(ptrX == 16'h1111 && ptrY == 16'h2222 && ptrU == 16'h3333 && ptrS == 16'h4444 && countW == 7,
          "R2 unknown code ignored", ptrX ^ ptrY ^ ptrU ^ ptrS ^ countW, 16'h4444 ^ 16'h0007);
  endtask

  task automatic testBothUp();
    int r0, w0;
    mem[12'h100] = 8'h11; mem[12'h101] = 8'h22; mem[12'h102] = 8'h33;
    setReg(CX, 16'h0100); setReg(CY, 16'h0180); setReg(CW, 16'd3);
    r0 = rdCnt; w0 = wrCnt;
    runXfer(2'd0, CX, CY, 0, 1'b0);
    check(lastCycles == 15, "R7 busy length 6+3n", lastCycles, 15);
    check(mem[12'h180] == 8'h11 && mem[12'h181] == 8'h22 && mem[12'h182] == 8'h33,
          "R3 copied bytes", {mem[12'h180], mem[12'h181], mem[12'h182]}, 24'h112233);
    check(ptrX == 16'h0103 && ptrY == 16'h0183, "R3 final pointers", {ptrX, ptrY}, 32'h01030183);
    check(countW == 0, "R8 count ends zero", countW, 0);
    check(rdCnt - r0 == 3 && wrCnt - w0 == 3, "R7 one read one write per byte", rdCnt - r0, 3);
  endtask

  task automatic testBothDown();
    mem[12'h203] = 8'hA3; mem[12'h204] = 8'hA4; mem[12'h205] = 8'hA5;
    setReg(CU, 16'h0205); setReg(CS, 16'h0305); setReg(CW, 16'd3);
    runXfer(2'd1, CU, CS, 0, 1'b0);
    check(mem[12'h303] == 8'hA3 && mem[12'h304] == 8'hA4 && mem[12'h305] == 8'hA5,
          "R4 copied bytes", {mem[12'h303], mem[12'h304], mem[12'h305]}, 24'hA3A4A5);
    check(ptrU == 16'h0202 && ptrS == 16'h0302, "R4 final pointers", {ptrU, ptrS}, 32'h02020302);
  endtask

  task automatic testToFixed();
    int w0;
    for (int i = 0; i < 4; i++) mem[12'h400 + i] = 8'h40 + 8'(i);
    mem[12'h7F0] = 8'h00; mem[12'h7F1] = 8'h00;
    setReg(CX, 16'h0400); setReg(CY, 16'h07F0); setReg(CW, 16'd4);
    w0 = wrCnt;
    runXfer(2'd2, CX, CY, 0, 1'b0);
    check(mem[12'h7F0] == 8'h43 && mem[12'h7F1] == 8'h00, "R5 fixed destination holds last byte",
          {mem[12'h7F0], mem[12'h7F1]}, 16'h4300);
    check(ptrX == 16'h0404 && ptrY == 16'h07F0, "R5 final pointers", {ptrX, ptrY}, 32'h040407F0);
    check(wrCnt - w0 == 4, "R5 write count", wrCnt - w0, 4);
  endtask

  task automatic testFromFixed();
    mem[12'h500] = 8'h5A; mem[12'h501] = 8'h99;
    setReg(CU, 16'h0500); setReg(CS, 16'h0600); setReg(CW, 16'd2);
    runXfer(2'd3, CU, CS, 0, 1'b0);
    check(mem[12'h600] == 8'h5A && mem[12'h601] == 8'h5A, "R6 same source byte twice",
          {mem[12'h600], mem[12'h601]}, 16'h5A5A);
    check(ptrU == 16'h0500 && ptrS == 16'h0602, "R6 final pointers", {ptrU, ptrS}, 32'h05000602);
  endtask

  task automatic testZeroCount();
    int r0, w0;
    setReg(CX, 16'h0900); setReg(CY, 16'h0A00); setReg(CW, 16'd0);
    r0 = rdCnt; w0 = wrCnt;
    runXfer(2'd0, CX, CY, 0, 1'b0);
    check(lastCycles == 6, "R9 overhead only", lastCycles, 6);
    check(rdCnt == r0 && wrCnt == w0, "R9 no memory access", (rdCnt - r0) + (wrCnt - w0), 0);
    check(ptrX == 16'h0900 && ptrY == 16'h0A00, "R9 pointers unchanged", {ptrX, ptrY}, 32'h09000A00);
  endtask

  task automatic testSamePointer();
    mem[12'h100] = 8'hC1; mem[12'h102] = 8'hC2;
    setReg(CX, 16'h0100); setReg(CW, 16'd2);
    runXfer(2'd0, CX, CX, 0, 1'b0);
    check(mem[12'h101] == 8'hC1 && mem[12'h103] == 8'hC2, "R10 source step precedes write",
          {mem[12'h101], mem[12'h103]}, 16'hC1C2);
    check(ptrX == 16'h0104, "R10 pointer stepped twice per byte", ptrX, 16'h0104);
  endtask

  task automatic testPause();
    int r0;
    mem[12'h800] = 8'h81; mem[12'h801] = 8'h82;
    setReg(CX, 16'h0800); setReg(CY, 16'h0880); setReg(CW, 16'd2);
    r0 = rdCnt;
    runXfer(2'd0, CX, CY, 10, 1'b0);
    check(midReads == r0 && midCount == 2 && midX == 16'h0800, "R11 paused state held",
          midReads - r0, 0);
    check(lastCycles == 18, "R11 pause adds stall cycles", lastCycles, 18);
    check(mem[12'h880] == 8'h81 && mem[12'h881] == 8'h82 && countW == 0, "R11 resumed transfer",
          {mem[12'h880], mem[12'h881]}, 16'h8182);
  endtask

  task automatic testRejects();
    @(negedge clk);
    start = 1'b1; mode = 2'd0; srcCode = 4'd0; dstCode = CY;
    @(negedge clk);
    start = 1'b0;
    check(!busy, "R12 invalid source code ignored", busy, 0);
    setReg(CX, 16'h0C00); setReg(CY, 16'h0D00); setReg(CW, 16'd1);
    runXfer(2'd0, CX, CY, 0, 1'b1);
    check(countW == 0, "R2 write while busy ignored", countW, 0);
    check(lastCycles == 9, "R12 start while busy ignored", lastCycles, 9);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testRegPort();
    testBothUp();
    testBothDown();
    testToFixed();
    testFromFixed();
    testZeroCount();
    testSamePointer();
    testPause();
    testRejects();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule